// File: doc/BRIEF.md
# Moving Inversions Memory Self-Test Sequencer

This block is a built-in self-test sequencer for one single-port synchronous RAM with one cycle of read latency. After a start request it runs a three-phase moving-inversions test over the whole address space, 0 to 2^AW-1. First it writes a seed word to every location. Next it climbs from address 0 and, at each address, reads the word, checks it against the seed, and writes back the inverted seed. Last it descends from the top address and, at each address, reads the word, checks it against the inverted seed, and writes the seed back. At every address the check comes before the write to that address. A word-wide RAM cannot be tested one bit at a time, so the seed is applied across the whole word.

The sequencer is built around one state machine with seven states:
- `ST_IDLE` goes to `ST_FILL` when start is accepted.
- `ST_FILL` stays in `ST_FILL` while it counts upward, and goes to `ST_UP_RD` after the top address.
- `ST_UP_RD` always goes to `ST_UP_WR`.
- `ST_UP_WR` goes back to `ST_UP_RD` at the next address, or to `ST_DN_RD` at the top address.
- `ST_DN_RD` always goes to `ST_DN_WR`.
- `ST_DN_WR` goes to `ST_DN_RD` at the address below, or to `ST_FINISH` at address 0.
- `ST_FINISH` asserts done for one cycle and returns to `ST_IDLE`.

The first mismatch sets a sticky fail flag and captures the failing address and the data that was read. The test still runs to the end. A test takes 5*2^AW+1 cycles.

Top module: `mi_bist`

## Requirements
- R1: After reset, busy, done, fail and mem_we are all 0. mem_we is never 1 while busy is 0.
- R2: Start is accepted in `ST_IDLE` on a rising clock edge. From the next cycle, the block writes the seed to addresses 0, 1, ..., 2^AW-1, one write per cycle (mem_we=1, mem_wdata=seed).
- R3: The ascending sweep then begins. For each address from 0 up to 2^AW-1 it spends one read cycle on that address (mem_we=0), then one write cycle on the same address with mem_wdata = bitwise inverse of the seed.
- R4: The descending sweep then begins. For each address from 2^AW-1 down to 0 it spends one read cycle, then one write cycle on the same address with mem_wdata = seed.
- R5: mem_rdata is sampled during the write cycle that follows each read cycle. The expected value is the seed in the ascending sweep and the inverted seed in the descending sweep.
- R6: On the first mismatch, fail goes to 1. fail_addr and fail_data capture the address and the observed word, and none of the three changes until the next accepted start, which clears all three.
- R7: done is 1 for exactly one cycle, the cycle after the last descending write. busy is 1 from the first fill cycle through the done cycle.
- R8: A start request while busy is 1 has no effect on the sequence or its timing.
- R9: The seed is captured from the pattern input when start is accepted. Later changes to the pattern input have no effect on the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in idle |
| pattern | input | DW | Seed word |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_data | output | DW | Word read at the first mismatch |

## Verification
The RAM interface is combinational from the state register. The first fill write therefore appears in the cycle right after the clock edge that accepts start, and each later operation follows one cycle after the previous one. fail, fail_addr and fail_data update one cycle after the write cycle in which the failing word is compared. The bench expands each test into a behavioural list of expected per-cycle operations and pops one entry at every falling edge. It predicts the first failure by playing the test against its own model of the faulty RAM. It checks the fail outputs in the cycle after the done cycle, and checks that they are cleared in the first fill cycle of the next test.

// File: rtl/mi_bist_pkg.sv
package mi_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_UP_RD  = 3'd2,
        ST_UP_WR  = 3'd3,
        ST_DN_RD  = 3'd4,
        ST_DN_WR  = 3'd5,
        ST_FINISH = 3'd6
    } mi_state_e;

    typedef enum logic {
        WORD_SEED = 1'b0,
        WORD_INV  = 1'b1
    } mi_word_e;

endpackage

// File: rtl/mi_bist_fsm.sv
module mi_bist_fsm
    import mi_bist_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] addr,
    output logic          we,
    output mi_word_e      wsel,
    output logic          cmp_en,
    output mi_word_e      cmp_sel,
    output logic          accept,
    output logic          busy,
    output logic          done
);

    localparam logic [AW-1:0] ADDR_TOP = '1;
    localparam logic [AW-1:0] ADDR_BOT = '0;
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);

    mi_state_e     state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    // next-state and address logic
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FILL;
                    addr_d  = ADDR_BOT;
                end
            end
            ST_FILL: begin
                if (addr_q == ADDR_TOP) begin
                    state_d = ST_UP_RD;
                    addr_d  = ADDR_BOT;
                end else begin
                    addr_d = addr_q + ADDR_ONE;
                end
            end
            ST_UP_RD: state_d = ST_UP_WR;
            ST_UP_WR: begin
                if (addr_q == ADDR_TOP) begin
                    state_d = ST_DN_RD;
                end else begin
                    state_d = ST_UP_RD;
                    addr_d  = addr_q + ADDR_ONE;
                end
            end
            ST_DN_RD: state_d = ST_DN_WR;
            ST_DN_WR: begin
                if (addr_q == ADDR_BOT) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_DN_RD;
                    addr_d  = addr_q - ADDR_ONE;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
                addr_d  = ADDR_BOT;
            end
            default: begin
                state_d = ST_IDLE;
                addr_d  = ADDR_BOT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= ADDR_BOT;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        we      = 1'b0;
        wsel    = WORD_SEED;
        cmp_en  = 1'b0;
        cmp_sel = WORD_SEED;
        busy    = 1'b1;
        done    = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_FILL: we = 1'b1;
            ST_UP_RD: ;
            ST_UP_WR: begin
                we     = 1'b1;
                wsel   = WORD_INV;
                cmp_en = 1'b1;
            end
            ST_DN_RD: ;
            ST_DN_WR: begin
                we      = 1'b1;
                cmp_en  = 1'b1;
                cmp_sel = WORD_INV;
            end
            ST_FINISH: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign addr = addr_q;

    p_up_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP_RD) |=> (state_q == ST_UP_WR && addr_q == $past(addr_q)));

    p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP_WR && addr_q != ADDR_TOP) |=>
            (state_q == ST_UP_RD && addr_q == $past(addr_q) + ADDR_ONE));

    p_dn_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DN_RD) |=> (state_q == ST_DN_WR && addr_q == $past(addr_q)));

    p_dn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DN_WR && addr_q != ADDR_BOT) |=>
            (state_q == ST_DN_RD && addr_q == $past(addr_q) - ADDR_ONE));

    p_turn_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP_WR && addr_q == ADDR_TOP) |=>
            (state_q == ST_DN_RD && addr_q == ADDR_TOP));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_FINISH) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/mi_bist_datapath.sv
module mi_bist_datapath
    import mi_bist_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] pattern,
    input  mi_word_e      wsel,
    input  mi_word_e      cmp_sel,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] expect_word
);

    logic [DW-1:0] seed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
        end else if (load) begin
            seed_q <= pattern;
        end
    end

    always_comb begin
        unique case (wsel)
            WORD_INV:  wdata = ~seed_q;
            default:   wdata = seed_q;
        endcase
        unique case (cmp_sel)
            WORD_INV:  expect_word = ~seed_q;
            default:   expect_word = seed_q;
        endcase
    end

    p_seed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(seed_q));

endmodule

// File: rtl/mi_bist_errlog.sv
module mi_bist_errlog #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cmp_en,
    input  logic [AW-1:0] cmp_addr,
    input  logic [DW-1:0] observed,
    input  logic [DW-1:0] expect_word,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);

    logic          fail_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          mismatch;

    assign mismatch = cmp_en && (observed != expect_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (clr) begin
            fail_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (mismatch && !fail_q) begin
            fail_q <= 1'b1;
            addr_q <= cmp_addr;
            data_q <= observed;
        end
    end

    assign fail      = fail_q;
    assign fail_addr = addr_q;
    assign fail_data = data_q;

    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr) |=> (fail_q && $stable(addr_q) && $stable(data_q)));

    p_fail_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fail_q);

    p_fail_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_q && !clr && !mismatch) |=> !fail_q);

endmodule

// File: rtl/mi_bist.sv
module mi_bist
    import mi_bist_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] pattern,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);

    logic          accept;
    logic          cmp_en;
    mi_word_e      wsel;
    mi_word_e      cmp_sel;
    logic [DW-1:0] expect_word;

    mi_bist_fsm #(.AW(AW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr    (mem_addr),
        .we      (mem_we),
        .wsel    (wsel),
        .cmp_en  (cmp_en),
        .cmp_sel (cmp_sel),
        .accept  (accept),
        .busy    (busy),
        .done    (done)
    );

    mi_bist_datapath #(.DW(DW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .pattern     (pattern),
        .wsel        (wsel),
        .cmp_sel     (cmp_sel),
        .wdata       (mem_wdata),
        .expect_word (expect_word)
    );

    mi_bist_errlog #(.AW(AW), .DW(DW)) u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (accept),
        .cmp_en      (cmp_en),
        .cmp_addr    (mem_addr),
        .observed    (mem_rdata),
        .expect_word (expect_word),
        .fail        (fail),
        .fail_addr   (fail_addr),
        .fail_data   (fail_data)
    );

    p_we_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/mi_bist_bench.sv
module mi_bist_bench;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          dn;
        string         tag;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] pattern = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_data;

    always #10 clk = ~clk;

    mi_bist #(.AW(AW), .DW(DW)) u_mi_bist (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_data(fail_data)
    );

    // RAM model with optional stuck-at-0 bits on two addresses
    logic [DW-1:0] ram [N];
    logic          flt_en = 1'b0;
    int            flt_a = 0, flt_b = 0;
    logic [DW-1:0] flt_m = '0;

    function automatic logic [DW-1:0] stuck_mask(int a);
        return (flt_en && (a == flt_a || a == flt_b)) ? flt_m : '0;
    endfunction

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr] & ~stuck_mask(int'(mem_addr));
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // runs one test; glitch_at >= 0 pulses start and changes pattern at that op
    task automatic run_test(logic [DW-1:0] seed, int glitch_at);
        op_t           q[$];
        op_t           e;
        logic [DW-1:0] mm [N];
        logic          exp_fail = 0;
        logic [AW-1:0] exp_fa = '0;
        logic [DW-1:0] exp_fd = '0;
        logic [DW-1:0] obs;
        // behavioural expansion of the test
        for (int i = 0; i < N; i++) begin
            q.push_back('{1'b1, AW'(i), seed, 1'b0, "R2"});
            mm[i] = seed;
        end
        for (int i = 0; i < N; i++) begin
            q.push_back('{1'b0, AW'(i), '0, 1'b0, "R3"});
            q.push_back('{1'b1, AW'(i), ~seed, 1'b0, "R3"});
            obs = mm[i] & ~stuck_mask(i);
            if (!exp_fail && obs != seed) begin
                exp_fail = 1; exp_fa = AW'(i); exp_fd = obs;
            end
            mm[i] = ~seed;
        end
        for (int i = N - 1; i >= 0; i--) begin
            q.push_back('{1'b0, AW'(i), '0, 1'b0, "R4"});
            q.push_back('{1'b1, AW'(i), seed, 1'b0, "R4"});
            obs = mm[i] & ~stuck_mask(i);
            if (!exp_fail && obs != ~seed) begin
                exp_fail = 1; exp_fa = AW'(i); exp_fd = obs;
            end
            mm[i] = seed;
        end
        q.push_back('{1'b0, '0, '0, 1'b1, "R7"});

        pattern = seed;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // first fill cycle: previous failure record cleared
        check(!fail && fail_addr == '0 && fail_data == '0, "R6", "clear on start",
              $sformatf("%0b/%0h/%0h", fail, fail_addr, fail_data), "0/0/0");
        for (int k = 0; q.size() > 0; k++) begin
            e = q.pop_front();
            if (e.dn) begin
                check(done && busy && !mem_we, e.tag, "done cycle",
                      $sformatf("done=%0b busy=%0b we=%0b", done, busy, mem_we),
                      "done=1 busy=1 we=0");
            end else begin
                check(busy && !done && mem_we == e.we && mem_addr == e.addr &&
                      (!e.we || mem_wdata == e.wdata), e.tag,
                      $sformatf("op %0d", k),
                      $sformatf("b%0b d%0b we%0b a%0h w%0h", busy, done, mem_we, mem_addr, mem_wdata),
                      $sformatf("b1 d0 we%0b a%0h w%0h", e.we, e.addr, e.wdata));
            end
            if (k == glitch_at) begin
                start = 1'b1;        // R8: ignored while busy
                pattern = ~seed ^ 8'h5A; // R9: ignored after capture
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(fail == exp_fail && fail_addr == exp_fa && fail_data == exp_fd, "R6",
              "fail record",
              $sformatf("%0b/%0h/%0h", fail, fail_addr, fail_data),
              $sformatf("%0b/%0h/%0h", exp_fail, exp_fa, exp_fd));
        for (int j = 0; j < 3; j++) begin
            check(!busy && !done && !mem_we, "R7", "idle after done",
                  $sformatf("b%0b d%0b we%0b", busy, done, mem_we), "b0 d0 we0");
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "reset state",
              $sformatf("b%0b d%0b f%0b we%0b", busy, done, fail, mem_we), "all 0");
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "idle after reset",
              $sformatf("b%0b d%0b f%0b we%0b", busy, done, fail, mem_we), "all 0");

        // clean RAM, R2 R3 R4 R5
        run_test(8'hA5, -1);
        // stuck bit 0 at address 5, seed bit 0 set: ascending sweep catches it (R5)
        flt_en = 1; flt_a = 5; flt_b = 5; flt_m = 8'h01;
        run_test(8'h0F, -1);
        // stuck bit 7 at 9, seed bit 7 clear: only the descending sweep catches it
        flt_a = 9; flt_b = 9; flt_m = 8'h80;
        run_test(8'h00, -1);
        // two faulty words: first one latched (R6)
        flt_a = 12; flt_b = 3; flt_m = 8'h01;
        run_test(8'hFF, -1);
        // clean RAM again; start and pattern changes mid-test (R8, R9)
        flt_en = 0;
        run_test(8'h3C, 20);
        run_test(8'hC3, 2 * N + 7);
        report();
    end

endmodule